// File: doc/BRIEF.md
# Transmit Host Handshake Controller

This block sits on the MAC side of the host transmit request interface. The host raises a start-of-packet request with the first frame byte already on the byte bus and holds the request until the controller acknowledges it. The acknowledge is a single-cycle pulse. The first byte is taken in that cycle. After it, the controller takes one byte per cycle for as long as the host keeps data-valid high, and passes each byte downstream on a registered forward port.

A frame ends when data-valid falls after the acknowledge. If data-valid is already low during the acknowledge cycle, the host has cancelled the request. The controller treats this as an underrun and raises a one-cycle abort pulse so that the host drops the current transmit cycle. A static mode input picks what a normal data-valid fall means: an end-of-frame marker, or an abort.

After every frame end or abort, an interframe gap timer restarts. No new acknowledge is issued until the timer has counted the full gap. A request that arrives during the gap is held by the host and is answered once the gap closes. A host that re-requests quickly after a frame therefore still runs back-to-back frames at the minimum gap.

Top module: `txh_ctrl`

## Requirements
- R1: During and after reset, with no request pending, `tx_ack_o`, `tx_abort_o`, `fwd_vld_o` and `fwd_end_o` are 0 and `gap_ok_o` is 1.
- R2: `tx_ack_o` is a one-cycle pulse. It rises only in the cycle after a cycle in which the controller was idle, `tx_sop_i` was 1 and `gap_ok_o` was 1. A request seen with the gap open is acknowledged one cycle later.
- R3: In the cycle after the acknowledge cycle, `fwd_vld_o` is 1 and `fwd_byte_o` equals the byte that was on `tx_byte_i` during the acknowledge. Each later cycle with `tx_dv_i` high forwards that cycle's byte one cycle later, in order.
- R4: If `tx_dv_i` is 0 during the acknowledge cycle, `tx_abort_o` pulses for one cycle in the next cycle, no byte is forwarded and `fwd_end_o` stays 0.
- R5: When `tx_dv_i` falls after the acknowledge cycle and `end_is_abort_i` is 0, `fwd_end_o` pulses for one cycle in the next cycle, one cycle after the last forwarded byte, and `tx_abort_o` stays 0.
- R6: When `tx_dv_i` falls after the acknowledge cycle and `end_is_abort_i` is 1, `tx_abort_o` pulses for one cycle in place of `fwd_end_o`.
- R7: From the cycle in which `fwd_end_o` or `tx_abort_o` pulses, `gap_ok_o` is 0 for exactly IFG_BYTES cycles (default 12) and then returns to 1. No acknowledge rises while it is 0.
- R8: If the host drops data-valid at a frame end and re-raises the request w cycles later (w >= 1), the acknowledge appears max(w+1, IFG_BYTES+2) cycles after the cycle in which data-valid was first low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sop_i | input | 1 | Host start-of-packet request, held until acknowledged |
| tx_dv_i | input | 1 | Host data-valid |
| tx_byte_i | input | DATA_W | Host frame byte |
| end_is_abort_i | input | 1 | 1: a data-valid fall after acknowledge aborts the frame; 0: it ends the frame normally |
| tx_ack_o | output | 1 | One-cycle acknowledge; the first byte is taken in this cycle |
| tx_abort_o | output | 1 | One-cycle pulse asking the host to abandon the transmit cycle |
| fwd_byte_o | output | DATA_W | Byte passed downstream |
| fwd_vld_o | output | 1 | `fwd_byte_o` carries a frame byte |
| fwd_end_o | output | 1 | One-cycle marker after the last byte of a normally ended frame |
| gap_ok_o | output | 1 | Interframe gap has elapsed |

## Verification
The hardest case to reach is a request that arrives while the gap is still closed, at every offset around the point where the gap closes. The bench has to show that the acknowledge waits for the gap and then follows at once. To get there, the driver re-raises the request at random and at directed distances after each frame end. Short distances of two cycles and the boundary offsets IFG_BYTES and IFG_BYTES+1 are among them. Each acknowledge time is compared with the expected delay function. The driver also drops data-valid exactly in the acknowledge cycle to reach the underrun abort, and it toggles the end-mode input between frames.

// File: rtl/txh_pkg.sv
`timescale 1ns/1ps
package txh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_SEND = 2'd2
    } txh_state_e;

    typedef struct packed {
        txh_state_e state;
        logic       ack;
        logic       abort;
        logic       fend;
    } txh_fsm_t;

endpackage

// File: rtl/txh_gap_timer.sv
`timescale 1ns/1ps
module txh_gap_timer #(
    parameter int IFG_BYTES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic open_o
);
    localparam int CNT_W = $clog2(IFG_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IFG_BYTES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_FULL) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_FULL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign open_o = (cnt_q == CNT_FULL);

endmodule

// File: rtl/txh_fsm.sv
`timescale 1ns/1ps
module txh_fsm
    import txh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sop_i,
    input  logic dv_i,
    input  logic end_is_abort_i,
    input  logic gap_open_i,
    output logic ack_o,
    output logic abort_o,
    output logic fend_o,
    output logic take_o,
    output logic restart_o
);
    txh_fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.ack   = 1'b0;
        fsm_d.abort = 1'b0;
        fsm_d.fend  = 1'b0;
        take_o      = 1'b0;
        restart_o   = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (sop_i && gap_open_i) begin
                    fsm_d.state = ST_ACK;
                    fsm_d.ack   = 1'b1;
                end
            end
            ST_ACK: begin
                if (dv_i) begin
                    take_o      = 1'b1;
                    fsm_d.state = ST_SEND;
                end else begin
                    fsm_d.abort = 1'b1;
                    restart_o   = 1'b1;
                    fsm_d.state = ST_IDLE;
                end
            end
            ST_SEND: begin
                if (dv_i) begin
                    take_o = 1'b1;
                end else begin
                    restart_o   = 1'b1;
                    fsm_d.state = ST_IDLE;
                    if (end_is_abort_i) begin
                        fsm_d.abort = 1'b1;
                    end else begin
                        fsm_d.fend = 1'b1;
                    end
                end
            end
            default: begin
                fsm_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
            fsm_q.ack   <= 1'b0;
            fsm_q.abort <= 1'b0;
            fsm_q.fend  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ack_o   = fsm_q.ack;
    assign abort_o = fsm_q.abort;
    assign fend_o  = fsm_q.fend;

endmodule

// File: rtl/txh_byte_pipe.sv
`timescale 1ns/1ps
module txh_byte_pipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              vld_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.vld  = take_i;
        pipe_d.data = take_i ? byte_i : pipe_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign byte_o = pipe_q.data;
    assign vld_o  = pipe_q.vld;

endmodule

// File: rtl/txh_ctrl.sv
`timescale 1ns/1ps
module txh_ctrl #(
    parameter int DATA_W    = 8,
    parameter int IFG_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sop_i,
    input  logic              tx_dv_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              end_is_abort_i,
    output logic              tx_ack_o,
    output logic              tx_abort_o,
    output logic [DATA_W-1:0] fwd_byte_o,
    output logic              fwd_vld_o,
    output logic              fwd_end_o,
    output logic              gap_ok_o
);
    logic take, restart, gap_open;

    txh_gap_timer #(.IFG_BYTES(IFG_BYTES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .open_o    (gap_open)
    );

    txh_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sop_i          (tx_sop_i),
        .dv_i           (tx_dv_i),
        .end_is_abort_i (end_is_abort_i),
        .gap_open_i     (gap_open),
        .ack_o          (tx_ack_o),
        .abort_o        (tx_abort_o),
        .fend_o         (fwd_end_o),
        .take_o         (take),
        .restart_o      (restart)
    );

    txh_byte_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .byte_i (tx_byte_i),
        .byte_o (fwd_byte_o),
        .vld_o  (fwd_vld_o)
    );

    assign gap_ok_o = gap_open;

endmodule

// File: rtl/txh_ctrl_chk.sv
`timescale 1ns/1ps
module txh_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_sop_i,
    input logic              tx_dv_i,
    input logic [DATA_W-1:0] tx_byte_i,
    input logic              tx_ack_o,
    input logic              tx_abort_o,
    input logic [DATA_W-1:0] fwd_byte_o,
    input logic              fwd_vld_o,
    input logic              fwd_end_o,
    input logic              gap_ok_o
);
    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack_o |=> !tx_ack_o);

    assert_ack_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ack_o) |-> $past(tx_sop_i) && $past(gap_ok_o));

    assert_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack_o && tx_dv_i) |=> fwd_vld_o && (fwd_byte_o == $past(tx_byte_i)));

    assert_underrun_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack_o && !tx_dv_i) |=> tx_abort_o && !fwd_vld_o && !fwd_end_o);

    assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort_o |=> !tx_abort_o);

    assert_end_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_end_o && tx_abort_o));

    assert_gap_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_end_o || tx_abort_o) |-> !gap_ok_o);

    assert_no_ack_in_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_ok_o |=> !tx_ack_o);

endmodule

bind txh_ctrl txh_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_sop_i   (tx_sop_i),
    .tx_dv_i    (tx_dv_i),
    .tx_byte_i  (tx_byte_i),
    .tx_ack_o   (tx_ack_o),
    .tx_abort_o (tx_abort_o),
    .fwd_byte_o (fwd_byte_o),
    .fwd_vld_o  (fwd_vld_o),
    .fwd_end_o  (fwd_end_o),
    .gap_ok_o   (gap_ok_o)
);

// File: tb/txh_ctrl_tb.sv
`timescale 1ns/1ps
module txh_ctrl_tb;
    localparam int DW  = 8;
    localparam int IFG = 12;
    localparam int MODE_NORMAL = 0;
    localparam int MODE_CANCEL = 1;
    localparam int MODE_ENDAB  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sop = 1'b0, dv = 1'b0, end_ab = 1'b0;
    logic [DW-1:0] din = '0;
    logic ack, abort, fvld, fend, gok;
    logic [DW-1:0] fbyte;

    int checks = 0;
    int fails = 0;
    int since_end = 0;
    bit after_reset = 1'b1;
    bit done = 1'b0;
    logic [DW-1:0] frame [0:63];

    always #2.5 clk = ~clk;

    txh_ctrl #(.DATA_W(DW), .IFG_BYTES(IFG)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_sop_i(sop), .tx_dv_i(dv), .tx_byte_i(din),
        .end_is_abort_i(end_ab), .tx_ack_o(ack), .tx_abort_o(abort),
        .fwd_byte_o(fbyte), .fwd_vld_o(fvld), .fwd_end_o(fend), .gap_ok_o(gok)
    );

    function automatic int exp_ack_delay(int w);
        return (w + 1 > IFG + 2) ? (w + 1) : (IFG + 2);
    endfunction

    function automatic bit exp_gap_ok(int d);
        return (d >= IFG + 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        since_end++;
    endtask

    task automatic run_frame(int len, int w, int mode);
        int d;
        for (int i = 0; i < len; i++) frame[i] = DW'($urandom);
        end_ab = (mode == MODE_ENDAB);
        while (!after_reset && since_end < w) begin
            tick();
            check(gok == exp_gap_ok(since_end), "R7 gap_ok while waiting", gok, exp_gap_ok(since_end));
            check(ack == 1'b0, "R7 no ack in gap", ack, 0);
        end
        sop = 1'b1; dv = 1'b1; din = frame[0];
        d = 0;
        while (ack !== 1'b1 && d < 100) begin
            tick();
            d++;
        end
        if (after_reset) check(d == 1, "R2 ack delay after reset", d, 1);
        else check(since_end == exp_ack_delay(w), "R8 ack delay", since_end, exp_ack_delay(w));
        after_reset = 1'b0;
        if (mode == MODE_CANCEL) begin
            dv = 1'b0; sop = 1'b0;
            since_end = 0;
            tick();
            check(abort == 1'b1 && fend == 1'b0, "R4 underrun abort", abort, 1);
            check(fvld == 1'b0, "R4 no byte forwarded", fvld, 0);
            check(ack == 1'b0, "R2 ack single cycle", ack, 0);
            return;
        end
        for (int i = 1; i < len; i++) begin
            tick();
            sop = 1'b0;
            if (i == 1) check(ack == 1'b0, "R2 ack single cycle", ack, 0);
            check(fvld == 1'b1 && fbyte == frame[i-1], "R3 forwarded byte", fbyte, frame[i-1]);
            din = frame[i];
        end
        tick();
        sop = 1'b0;
        check(fvld == 1'b1 && fbyte == frame[len-1], "R3 last byte", fbyte, frame[len-1]);
        check(fend == 1'b0 && abort == 1'b0, "R5 no early end", fend, 0);
        dv = 1'b0;
        since_end = 0;
        tick();
        check(fvld == 1'b0, "R3 no byte after end", fvld, 0);
        if (mode == MODE_NORMAL)
            check(fend == 1'b1 && abort == 1'b0, "R5 end marker", fend, 1);
        else
            check(abort == 1'b1 && fend == 1'b0, "R6 end as abort", abort, 1);
        check(gok == 1'b0, "R7 gap closed at end", gok, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        check(ack == 0 && abort == 0 && fvld == 0 && fend == 0 && gok == 1, "R1 reset state", {ack, abort, fvld, fend}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack == 0 && abort == 0 && fvld == 0 && fend == 0 && gok == 1, "R1 idle after reset", {ack, abort, fvld, fend}, 0);
        // directed corner cases
        run_frame(1, 2, MODE_NORMAL);
        run_frame(4, 2, MODE_NORMAL);
        run_frame(3, IFG, MODE_ENDAB);
        run_frame(2, IFG + 1, MODE_CANCEL);
        run_frame(5, 6, MODE_NORMAL);
        run_frame(1, IFG + 5, MODE_CANCEL);
        run_frame(6, 3, MODE_ENDAB);
        // constrained random
        for (int k = 0; k < 300; k++) begin
            int m;
            m = int'($urandom_range(0, 9));
            run_frame(int'($urandom_range(1, 40)), int'($urandom_range(2, 20)),
                      (m < 6) ? MODE_NORMAL : ((m < 8) ? MODE_CANCEL : MODE_ENDAB));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule